// File: doc/BRIEF.md
# Vector Widening Carry-less Multiplier

This unit performs a polynomial multiply over GF(2) on packed vectors, with each result twice as wide as its sources. Two source vectors are split into elements of 8, 32 or 64 bits. Each output lane is twice the element width. Each lane takes one element from each source, either the even-indexed one or the odd-indexed one, and forms their carry-less product. Partial products are combined with XOR, so no carry ever moves between bit positions.

A two-bit size code picks the element width. Code 2 has no meaning and is rejected. Code 0 selects the 64-bit to 128-bit form, which is legal only when the feature-level input reaches a threshold (2 by default). A rejected operation returns an all-zero vector with the write enable low and the illegal flag high. All lanes are computed in parallel. The result is registered, so it appears exactly one clock after the request.

Top module: `vclm_widen_top`

## Requirements
- R1: Each lane result is the carry-less product of its two selected elements: for every set bit i of the first element, the second element shifted left by i is XORed into a result of twice the element width (e.g. 0x03 x 0x03 = 0x0005, 0x87 x 0x02 = 0x010E).
- R2: Size code 1 multiplies 8-bit elements into 16-bit lanes (8 lanes for a 128-bit vector) and is always legal.
- R3: Size code 3 multiplies 32-bit elements into 64-bit lanes (2 lanes for a 128-bit vector) and is always legal.
- R4: Size code 0 multiplies 64-bit elements into 128-bit lanes when poly_level is 2 or higher.
- R5: Size code 0 with poly_level below 2 is illegal.
- R6: Size code 2 is illegal for every poly_level.
- R7: With sel_odd = 0, output lane k uses source element 2k of both vectors. With sel_odd = 1, it uses element 2k+1. Element 0 occupies the least significant bits.
- R8: On an illegal operation, out_illegal is 1, result is all zeros and out_wen is 0. On a legal one, out_illegal is 0 and out_wen is 1.
- R9: out_valid is high exactly one clock after a cycle with in_valid high and low otherwise. When in_valid is low, result, out_illegal and out_wen keep the values of the last operation, except that out_wen is forced low.
- R10: While reset is active, out_valid, out_wen and out_illegal are 0 and result is zero.
- R11: A zero operand gives a zero product. An operand of value 1 returns the other element zero-extended to the lane width. All-ones operands give alternating bits 0101..01 across the lane (0x5555 for 8-bit elements).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation request this cycle |
| src_a | input | VLEN | First source vector |
| src_b | input | VLEN | Second source vector |
| size_code | input | 2 | Element size: 0 = 64-bit, 1 = 8-bit, 2 = reserved, 3 = 32-bit |
| sel_odd | input | 1 | 0 = even elements, 1 = odd elements |
| poly_level | input | LVL_W | Feature level that gates size code 0 |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| out_wen | output | 1 | Destination write enable |
| out_illegal | output | 1 | Operation was rejected |
| result | output | VLEN | Packed double-width products |

## Verification
Every result, the illegal flag and the write enable belong to the rising edge that follows the in_valid cycle. The bench drives each request on a falling edge and reads the outputs on the next falling edge, half a period after that capturing edge, and then lowers in_valid. The hold checks sample one cycle later still, after an idle cycle with changed inputs. That confirms out_valid and out_wen dropped while result kept the earlier value.

// File: rtl/vclm_pkg.sv
package vclm_pkg;

   typedef enum logic [1:0] {
      SZ_QUAD = 2'd0,
      SZ_BYTE = 2'd1,
      SZ_RSVD = 2'd2,
      SZ_WORD = 2'd3
   } vclm_size_e;

   typedef enum logic [1:0] {
      PICK_NONE = 2'd0,
      PICK_BYTE = 2'd1,
      PICK_WORD = 2'd2,
      PICK_QUAD = 2'd3
   } vclm_pick_e;

   localparam int unsigned ELEM_BYTE = 8;
   localparam int unsigned ELEM_WORD = 32;
   localparam int unsigned ELEM_QUAD = 64;
   localparam int unsigned VEC_GRAIN = 128;

endpackage

// File: rtl/vclm_decode.sv
module vclm_decode #(
   parameter int unsigned LVL_W    = 2,
   parameter int unsigned WIDE_LVL = 2,
   parameter bit          WIDE_EN  = 1'b1
) (
   input  logic [1:0]             size_code,
   input  logic [LVL_W-1:0]       poly_level,
   output vclm_pkg::vclm_pick_e   pick,
   output logic                   illegal
);
   import vclm_pkg::*;

   localparam logic [LVL_W-1:0] LVL_MIN = LVL_W'(WIDE_LVL);

   logic wide_ok;

   generate
      if (WIDE_EN) begin : g_wide_gate
         assign wide_ok = (poly_level >= LVL_MIN);
      end else begin : g_wide_off
         assign wide_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      pick    = PICK_NONE;
      illegal = 1'b1;
      case (size_code)
         SZ_BYTE: begin
            pick    = PICK_BYTE;
            illegal = 1'b0;
         end
         SZ_WORD: begin
            pick    = PICK_WORD;
            illegal = 1'b0;
         end
         SZ_QUAD: begin
            if (wide_ok) begin
               pick    = PICK_QUAD;
               illegal = 1'b0;
            end
         end
         default: begin
            pick    = PICK_NONE;
            illegal = 1'b1;
         end
      endcase
   end

   always_comb begin
      if (size_code == SZ_RSVD) begin
         assert_rsvd_dec_R6: assert (illegal);
      end
   end

endmodule

// File: rtl/vclm_lane.sv
module vclm_lane #(
   parameter int unsigned SW = 8
) (
   input  logic [2*SW-1:0] a_pair,
   input  logic [2*SW-1:0] b_pair,
   input  logic            sel_odd,
   output logic [2*SW-1:0] prod
);
   localparam int unsigned PW = 2 * SW;

   logic [SW-1:0] a_el;
   logic [SW-1:0] b_el;

   assign a_el = sel_odd ? a_pair[PW-1:SW] : a_pair[SW-1:0];
   assign b_el = sel_odd ? b_pair[PW-1:SW] : b_pair[SW-1:0];

   always_comb begin
      prod = '0;
      for (int i = 0; i < SW; i++) begin
         if (a_el[i]) begin
            prod = prod ^ (PW'(b_el) << i);
         end
      end
   end

   always_comb begin
      if (b_el == '0) begin
         assert_zero_lane_R11: assert (prod == '0);
      end
   end

endmodule

// File: rtl/vclm_array.sv
module vclm_array #(
   parameter int unsigned VLEN = 128,
   parameter int unsigned SW   = 8
) (
   input  logic [VLEN-1:0] src_a,
   input  logic [VLEN-1:0] src_b,
   input  logic            sel_odd,
   output logic [VLEN-1:0] prod
);
   localparam int unsigned PW    = 2 * SW;
   localparam int unsigned LANES = VLEN / PW;

   generate
      if (VLEN % PW != 0) begin : g_bad_split
         $error("vclm_array: VLEN is not a multiple of the lane width");
      end
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         vclm_lane #(.SW(SW)) u_lane (
            .a_pair  (src_a[g*PW +: PW]),
            .b_pair  (src_b[g*PW +: PW]),
            .sel_odd (sel_odd),
            .prod    (prod[g*PW +: PW])
         );
      end
   endgenerate

endmodule

// File: rtl/vclm_widen_top.sv
module vclm_widen_top #(
   parameter int unsigned VLEN     = 128,
   parameter int unsigned LVL_W    = 2,
   parameter int unsigned WIDE_LVL = 2,
   parameter bit          WIDE_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [VLEN-1:0]  src_a,
   input  logic [VLEN-1:0]  src_b,
   input  logic [1:0]       size_code,
   input  logic             sel_odd,
   input  logic [LVL_W-1:0] poly_level,
   output logic             out_valid,
   output logic             out_wen,
   output logic             out_illegal,
   output logic [VLEN-1:0]  result
);
   import vclm_pkg::*;

   localparam logic [LVL_W-1:0] LVL_MIN = LVL_W'(WIDE_LVL);

   generate
      if (VLEN == 0 || (VLEN % VEC_GRAIN) != 0) begin : g_bad_vlen
         $error("vclm_widen_top: VLEN must be a nonzero multiple of 128");
      end
      if (LVL_W == 0 || LVL_W > 8) begin : g_bad_lvlw
         $error("vclm_widen_top: LVL_W out of range");
      end
      if (WIDE_LVL >= (1 << LVL_W)) begin : g_bad_lvl
         $error("vclm_widen_top: WIDE_LVL not reachable with LVL_W bits");
      end
   endgenerate

   vclm_pick_e      pick;
   logic            dec_illegal;
   logic [VLEN-1:0] prod_byte;
   logic [VLEN-1:0] prod_word;
   logic [VLEN-1:0] prod_quad;
   logic [VLEN-1:0] prod_sel;

   logic            valid_q;
   logic            illegal_q;
   logic [VLEN-1:0] result_q;

   vclm_decode #(
      .LVL_W    (LVL_W),
      .WIDE_LVL (WIDE_LVL),
      .WIDE_EN  (WIDE_EN)
   ) u_decode (
      .size_code  (size_code),
      .poly_level (poly_level),
      .pick       (pick),
      .illegal    (dec_illegal)
   );

   vclm_array #(.VLEN(VLEN), .SW(ELEM_BYTE)) u_arr_byte (
      .src_a   (src_a),
      .src_b   (src_b),
      .sel_odd (sel_odd),
      .prod    (prod_byte)
   );

   vclm_array #(.VLEN(VLEN), .SW(ELEM_WORD)) u_arr_word (
      .src_a   (src_a),
      .src_b   (src_b),
      .sel_odd (sel_odd),
      .prod    (prod_word)
   );

   generate
      if (WIDE_EN) begin : g_quad
         vclm_array #(.VLEN(VLEN), .SW(ELEM_QUAD)) u_arr_quad (
            .src_a   (src_a),
            .src_b   (src_b),
            .sel_odd (sel_odd),
            .prod    (prod_quad)
         );
      end else begin : g_no_quad
         assign prod_quad = '0;
      end
   endgenerate

   always_comb begin
      case (pick)
         PICK_BYTE: prod_sel = prod_byte;
         PICK_WORD: prod_sel = prod_word;
         PICK_QUAD: prod_sel = prod_quad;
         default:   prod_sel = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q   <= 1'b0;
         illegal_q <= 1'b0;
         result_q  <= '0;
      end else begin
         valid_q <= in_valid;
         if (in_valid) begin
            illegal_q <= dec_illegal;
            result_q  <= dec_illegal ? '0 : prod_sel;
         end
      end
   end

   assign out_valid   = valid_q;
   assign out_illegal = illegal_q;
   assign out_wen     = valid_q & ~illegal_q;
   assign result      = result_q;

   assert_lat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_wen));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));

   assert_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> (result == '0 && !out_wen));

   assert_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && size_code == 2'd2) |=> out_illegal);

   assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && size_code == 2'd0 && poly_level < LVL_MIN) |=> out_illegal);

   assert_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && size_code == 2'd1) |=> (out_wen && !out_illegal));

   assert_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && size_code == 2'd3) |=> (out_wen && !out_illegal));

endmodule

// File: tb/vclm_widen_top_tb.sv
`timescale 1ns/1ps
module vclm_widen_top_tb_top;

   localparam int unsigned VLEN = 128;

   typedef struct packed {
      logic [1:0]      sz;
      logic            sel;
      logic [1:0]      lvl;
      logic [VLEN-1:0] a;
      logic [VLEN-1:0] b;
   } vec_t;

   localparam logic [VLEN-1:0] ONES = {VLEN{1'b1}};
   localparam logic [VLEN-1:0] P1 = 128'h0123456789ABCDEF_FEDCBA9876543210;
   localparam logic [VLEN-1:0] P2 = 128'hDEADBEEF_CAFEF00D_13579BDF_2468ACE0;
   localparam logic [VLEN-1:0] P3 = 128'h80000001_80000001_F0F00F0F_C3C33C3C;
   localparam int NV = 10;
   localparam vec_t VECS [0:NV-1] = '{
      '{2'd1, 1'b0, 2'd0, ONES, ONES},
      '{2'd1, 1'b1, 2'd0, P1, P2},
      '{2'd3, 1'b0, 2'd0, ONES, ONES},
      '{2'd3, 1'b1, 2'd0, P1, P2},
      '{2'd0, 1'b0, 2'd2, ONES, ONES},
      '{2'd0, 1'b1, 2'd3, P1, P2},
      '{2'd0, 1'b0, 2'd1, P1, P2},
      '{2'd2, 1'b0, 2'd3, P1, P2},
      '{2'd3, 1'b0, 2'd0, P2, P1},
      '{2'd1, 1'b0, 2'd0, P3, P1}
   };

   logic            clk;
   logic            rst_n;
   logic            in_valid;
   logic [VLEN-1:0] src_a;
   logic [VLEN-1:0] src_b;
   logic [1:0]      size_code;
   logic            sel_odd;
   logic [1:0]      poly_level;
   logic            out_valid;
   logic            out_wen;
   logic            out_illegal;
   logic [VLEN-1:0] result;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   vclm_widen_top #(.VLEN(VLEN)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .src_a       (src_a),
      .src_b       (src_b),
      .size_code   (size_code),
      .sel_odd     (sel_odd),
      .poly_level  (poly_level),
      .out_valid   (out_valid),
      .out_wen     (out_wen),
      .out_illegal (out_illegal),
      .result      (result)
   );

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   function automatic bit exp_illegal(logic [1:0] sz, logic [1:0] lvl);
      return (sz == 2'd2) || (sz == 2'd0 && lvl < 2'd2);
   endfunction

   function automatic logic [VLEN-1:0] ref_prod(logic [1:0] sz, logic sel, logic [1:0] lvl,
                                               logic [VLEN-1:0] a, logic [VLEN-1:0] b);
      logic [VLEN-1:0] res;
      int sw;
      res = '0;
      if (exp_illegal(sz, lvl)) return res;
      sw = (sz == 2'd1) ? 8 : (sz == 2'd3) ? 32 : 64;
      for (int k = 0; k < VLEN / (2 * sw); k++) begin
         logic [127:0] ea, eb, mask, acc;
         mask = (sw == 64) ? {64'd0, {64{1'b1}}} : ((128'd1 << sw) - 128'd1);
         ea   = (128'(a) >> ((2 * k + int'(sel)) * sw)) & mask;
         eb   = (128'(b) >> ((2 * k + int'(sel)) * sw)) & mask;
         acc  = '0;
         for (int j = 0; j < sw; j++) begin
            if (eb[j]) acc = acc ^ (ea << j);
         end
         res = res | (VLEN'(acc) << (k * 2 * sw));
      end
      return res;
   endfunction

   function automatic string tag_of(logic [1:0] sz, logic [1:0] lvl);
      case (sz)
         2'd1:    return "R2";
         2'd3:    return "R3";
         2'd2:    return "R6";
         default: return (lvl >= 2'd2) ? "R4" : "R5";
      endcase
   endfunction

   task automatic chk_vec(string tag, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s result act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic chk_bit(string tag, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
      end
   endtask

   task automatic issue(logic [1:0] sz, logic sel, logic [1:0] lvl,
                        logic [VLEN-1:0] a, logic [VLEN-1:0] b);
      @(negedge clk);
      in_valid   = 1'b1;
      size_code  = sz;
      sel_odd    = sel;
      poly_level = lvl;
      src_a      = a;
      src_b      = b;
      @(negedge clk);
      in_valid   = 1'b0;
   endtask

   task automatic run_full(string tag, logic [1:0] sz, logic sel, logic [1:0] lvl,
                           logic [VLEN-1:0] a, logic [VLEN-1:0] b);
      bit il;
      il = exp_illegal(sz, lvl);
      issue(sz, sel, lvl, a, b);
      chk_bit(tag, "out_valid", out_valid, 1'b1);
      chk_bit(tag, "out_illegal", out_illegal, il);
      chk_bit(tag, "out_wen", out_wen, !il);
      chk_vec(tag, result, ref_prod(sz, sel, lvl, a, b));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n      = 1'b0;
      in_valid   = 1'b0;
      src_a      = '0;
      src_b      = '0;
      size_code  = 2'd1;
      sel_odd    = 1'b0;
      poly_level = 2'd0;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk_bit("R10", "out_valid", out_valid, 1'b0);
      chk_bit("R10", "out_wen", out_wen, 1'b0);
      chk_bit("R10", "out_illegal", out_illegal, 1'b0);
      chk_vec("R10", result, '0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         run_full(tag_of(VECS[i].sz, VECS[i].sel),
                  VECS[i].sz, VECS[i].sel, VECS[i].lvl, VECS[i].a, VECS[i].b);
      end

      // R1: hand-computed byte products in lanes 0 and 1
      issue(2'd1, 1'b0, 2'd0, 128'h0087_0003, 128'h0002_0003);
      chk_vec("R1", result, 128'h010E_0005);
      chk_bit("R1", "out_wen", out_wen, 1'b1);

      // R7: odd select ignores the even bytes, then picks the odd ones
      issue(2'd1, 1'b1, 2'd0, 128'h0087_0003, 128'h0002_0003);
      chk_vec("R7", result, '0);
      issue(2'd1, 1'b1, 2'd0, 128'h0300, 128'h0300);
      chk_vec("R7", result, 128'h0005);

      // R11: all-ones operands for every legal size
      issue(2'd1, 1'b0, 2'd0, ONES, ONES);
      chk_vec("R11", result, {8{16'h5555}});
      issue(2'd3, 1'b1, 2'd0, ONES, ONES);
      chk_vec("R11", result, {2{64'h5555_5555_5555_5555}});
      issue(2'd0, 1'b0, 2'd2, ONES, ONES);
      chk_vec("R11", result, {128'h5555_5555_5555_5555_5555_5555_5555_5555});

      // R11: multiply by one and by zero
      issue(2'd3, 1'b0, 2'd0, 128'hAAAAAAAA_12345678_BBBBBBBB_DEADBEEF,
            128'h00000000_00000001_00000000_00000001);
      chk_vec("R11", result, 128'h00000000_12345678_00000000_DEADBEEF);
      issue(2'd0, 1'b1, 2'd3, P1, 128'h00000000_00000001_00000000_00000000);
      chk_vec("R11", result, {64'd0, P1[127:64]});
      issue(2'd3, 1'b0, 2'd0, P1, '0);
      chk_vec("R11", result, '0);
      chk_bit("R11", "out_wen", out_wen, 1'b1);

      // R4 / R5: feature gate on the widest size, with product that would be nonzero
      issue(2'd0, 1'b0, 2'd1, ONES, ONES);
      chk_bit("R5", "out_illegal", out_illegal, 1'b1);
      chk_vec("R8", result, '0);
      chk_bit("R8", "out_wen", out_wen, 1'b0);
      issue(2'd0, 1'b0, 2'd0, ONES, ONES);
      chk_bit("R5", "out_illegal", out_illegal, 1'b1);
      issue(2'd0, 1'b0, 2'd2, 128'h3, 128'h3);
      chk_bit("R4", "out_illegal", out_illegal, 1'b0);
      chk_vec("R4", result, 128'h5);

      // R6: reserved code at top level
      issue(2'd2, 1'b1, 2'd3, ONES, ONES);
      chk_bit("R6", "out_illegal", out_illegal, 1'b1);
      chk_vec("R6", result, '0);

      // R9: idle cycle with changed inputs leaves result, drops valid and wen
      issue(2'd1, 1'b0, 2'd0, 128'h03, 128'h03);
      chk_vec("R9", result, 128'h5);
      size_code = 2'd3;
      src_a     = ONES;
      src_b     = ONES;
      @(negedge clk);
      chk_bit("R9", "out_valid", out_valid, 1'b0);
      chk_bit("R9", "out_wen", out_wen, 1'b0);
      chk_vec("R9", result, 128'h5);
      chk_bit("R9", "out_illegal", out_illegal, 1'b0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule